// File: doc/BRIEF.md
# Bus START/STOP condition sequencer

This block is the part of a two-wire serial bus master that creates START and STOP conditions. It controls the data line only, through an open-drain pull-down enable. It never touches the clock line. When the clock line has to move, it raises a rise or fall request to a separate clock-control block. It then waits for that block's one-cycle edge pulse before it goes on. The block follows the clock level from these edge pulses, assuming the level is high after reset. It also takes a delayed falling-edge pulse, which marks the point where the data line may change while the clock is low. Separate bus-condition detectors supply pulses that confirm each START or STOP on the bus.

The caller asserts a START or a STOP command. The block looks at the present clock level and data level and picks one of six paths. Along the chosen path it inserts extra clock requests, so that the condition is always made legally with the clock high. After each step it waits for the pulse that confirms it, not for a fixed number of cycles. A one-cycle done pulse ends every sequence.

Between a change of the data enable (or the entry into a request state) and the clock request that follows, the block waits a settle time of `SETTLE` cycles (default 5).

States: `ST_IDLE`, `ST_S_DROP`, `ST_S_WLATE`, `ST_S_RAISE`, `ST_S_PULL`, `ST_S_LOWER`, `ST_P_DROP`, `ST_P_WLATE`, `ST_P_RAISE`, `ST_P_FREE`, `ST_P_WAITHI` and `ST_DONE`.

Transitions out of `ST_IDLE` (taken only on an accepted command):
- START, clock high, data high: to `ST_S_PULL`.
- START, clock high, data low: to `ST_S_DROP`.
- START, clock low: to `ST_S_WLATE`.
- STOP, clock high, data high: to `ST_P_DROP`.
- STOP, clock high, data low: to `ST_P_WAITHI`.
- STOP, clock low: to `ST_P_WLATE`.

Transitions on the START path:
- `ST_S_DROP` goes to `ST_S_WLATE` on a fall pulse.
- `ST_S_WLATE` goes to `ST_S_RAISE` once the delayed-fall flag is set.
- `ST_S_RAISE` goes to `ST_S_PULL` on a rise pulse.
- `ST_S_PULL` goes to `ST_S_LOWER` on a START-seen pulse.
- `ST_S_LOWER` goes to `ST_DONE` on a fall pulse.

Transitions on the STOP path:
- `ST_P_DROP` goes to `ST_P_WLATE` on a fall pulse.
- `ST_P_WLATE` goes to `ST_P_RAISE` once the delayed-fall flag is set.
- `ST_P_RAISE` goes to `ST_P_FREE` on a rise pulse.
- `ST_P_FREE` goes to `ST_DONE` on a STOP-seen pulse.
- `ST_P_WAITHI` goes to `ST_DONE` when the data line reads high.

`ST_DONE` always returns to `ST_IDLE`.

Top module: `bus_cond_sequencer`

## Requirements
- R1: `sda_pull` = 1 pulls the data line low, and `sda_pull` = 0 releases it. A START is made by the block's own pull-down while the clock is high.
- R2: `req_rise` and `req_fall` are never high together. A request, once raised, stays high until the matching edge pulse arrives.
- R3: START with clock high and data high produces this bus order: START condition, clock fall, done.
- R4: START with clock high and data held low by another device first requests a clock fall, then a clock rise. Only then does the block pull data low. Bus order: fall, rise, START, fall, done.
- R5: START with the clock low (repeated START) waits for the delayed-fall flag and keeps data released while it requests a rise. Bus order: rise, START, fall, done.
- R6: STOP with the clock low pulls data low, requests a rise and then releases data. Bus order: rise, STOP, done. No further clock request follows, so the clock stays high.
- R7: STOP with clock high and data high produces this bus order: fall, rise, STOP, done.
- R8: STOP with clock high while another device holds data low never asserts `sda_pull`. Done follows once data reads high, so the bus order is STOP, done.
- R9: After each entry into a request state, the clock request waits `SETTLE` cycles. On the STOP path the gap from `sda_pull` rising to `req_rise` rising is exactly `SETTLE` cycles.
- R10: `done` is high for exactly one cycle. From the cycle after `done` on, `sda_pull`, `req_rise` and `req_fall` stay low until a new command is accepted.
- R11: While `rst_n` is low (synchronous, active low), and just after it is released, `sda_pull`, `req_rise`, `req_fall` and `done` are all low.
- R12: A command kept high after `done` starts nothing until both commands have been low and one is raised again.
- R13: Commands that arrive during a sequence are ignored. When START and STOP are raised in the same cycle, START wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Request a START condition |
| cmd_stop | input | 1 | Request a STOP condition |
| sda_in | input | 1 | Sampled data line level |
| scl_rise_pulse | input | 1 | One-cycle pulse: clock line rose |
| scl_fall_pulse | input | 1 | One-cycle pulse: clock line fell |
| scl_fall_late_pulse | input | 1 | One-cycle pulse: delayed clock fall, data may now change |
| start_seen | input | 1 | One-cycle pulse: START detected on the bus |
| stop_seen | input | 1 | One-cycle pulse: STOP detected on the bus |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| req_rise | output | 1 | Ask the clock controller to release the clock high |
| req_fall | output | 1 | Ask the clock controller to pull the clock low |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
Some properties are checked on every cycle by the assertions. The two requests never overlap, and a raised request is held until its edge pulse. Done lasts one cycle and is followed by a quiet bus interface. No clock request rises in the same cycle as a change of the data enable. The settle counter never exceeds its limit, and the delayed-fall flag rises only with the clock low.

Other behaviour only the bench's scenarios can show. These are the order of bus events on each of the six paths and the exact settle gap on the STOP path. They also include the silence of the data enable when another device holds the line low, and the effect of held, overlapping or mid-sequence commands. The bench models the clock controller and the condition detectors to produce these.

// File: rtl/bcs_pkg.sv
`timescale 1ns/1ps
package bcs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_S_DROP,
        ST_S_WLATE,
        ST_S_RAISE,
        ST_S_PULL,
        ST_S_LOWER,
        ST_P_DROP,
        ST_P_WLATE,
        ST_P_RAISE,
        ST_P_FREE,
        ST_P_WAITHI,
        ST_DONE
    } bcs_state_e;

endpackage

// File: rtl/bcs_line_tracker.sv
`timescale 1ns/1ps
// Follows the clock line level from edge pulses and remembers whether the
// delayed fall marker has arrived since the last fall.
module bcs_line_tracker (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_p,
    input  logic fall_p,
    input  logic late_p,
    output logic scl_hi,
    output logic late_ok
);

    logic scl_q;
    logic late_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q  <= 1'b1;
            late_q <= 1'b1;
        end else begin
            if (fall_p) begin
                scl_q  <= 1'b0;
                late_q <= 1'b0;
            end else begin
                if (rise_p) scl_q <= 1'b1;
                if (late_p) late_q <= 1'b1;
            end
        end
    end

    assign scl_hi  = scl_q;
    assign late_ok = late_q;

    // R5: the delayed marker only becomes valid while the clock is low
    assert_late_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(late_q) |-> !scl_q);

endmodule

// File: rtl/bcs_settle_timer.sv
`timescale 1ns/1ps
// Down counter reloaded on each state entry; settled once it reaches zero.
module bcs_settle_timer #(
    parameter int SETTLE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic settled
);

    localparam int CW = (SETTLE > 0) ? $clog2(SETTLE + 1) : 1;
    localparam logic [CW-1:0] LOADV = CW'(SETTLE);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= LOADV;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign settled = (cnt_q == '0);

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOADV);

    assert_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt_q == LOADV));

endmodule

// File: rtl/bcs_seq_fsm.sv
`timescale 1ns/1ps
module bcs_seq_fsm
    import bcs_pkg::*;
#(
    parameter int SETTLE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic sda_in,
    input  logic scl_hi,
    input  logic late_ok,
    input  logic rise_p,
    input  logic fall_p,
    input  logic start_seen,
    input  logic stop_seen,
    input  logic settled,
    output logic tmr_load,
    output logic sda_pull,
    output logic req_rise,
    output logic req_fall,
    output logic done
);

    bcs_state_e state_q, state_d;
    logic       armed_q;
    logic       accept;

    assign accept   = (state_q == ST_IDLE) && armed_q && (cmd_start || cmd_stop);
    assign tmr_load = (state_d != state_q);

    // state register and command arming
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            armed_q <= 1'b1;
        end else begin
            state_q <= state_d;
            if (accept) begin
                armed_q <= 1'b0;
            end else if (!cmd_start && !cmd_stop) begin
                armed_q <= 1'b1;
            end
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (cmd_start) begin
                        if (!scl_hi)     state_d = ST_S_WLATE;
                        else if (sda_in) state_d = ST_S_PULL;
                        else             state_d = ST_S_DROP;
                    end else begin
                        if (!scl_hi)     state_d = ST_P_WLATE;
                        else if (sda_in) state_d = ST_P_DROP;
                        else             state_d = ST_P_WAITHI;
                    end
                end
            end
            ST_S_DROP:   if (fall_p)     state_d = ST_S_WLATE;
            ST_S_WLATE:  if (late_ok)    state_d = ST_S_RAISE;
            ST_S_RAISE:  if (rise_p)     state_d = ST_S_PULL;
            ST_S_PULL:   if (start_seen) state_d = ST_S_LOWER;
            ST_S_LOWER:  if (fall_p)     state_d = ST_DONE;
            ST_P_DROP:   if (fall_p)     state_d = ST_P_WLATE;
            ST_P_WLATE:  if (late_ok)    state_d = ST_P_RAISE;
            ST_P_RAISE:  if (rise_p)     state_d = ST_P_FREE;
            ST_P_FREE:   if (stop_seen)  state_d = ST_DONE;
            ST_P_WAITHI: if (sda_in)     state_d = ST_DONE;
            ST_DONE:                     state_d = ST_IDLE;
            default:                     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        req_rise = 1'b0;
        req_fall = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_S_DROP:   req_fall = settled;
            ST_S_RAISE:  req_rise = settled;
            ST_S_PULL:   sda_pull = 1'b1;
            ST_S_LOWER: begin
                sda_pull = 1'b1;
                req_fall = settled;
            end
            ST_P_DROP:   req_fall = settled;
            ST_P_RAISE: begin
                sda_pull = 1'b1;
                req_rise = settled;
            end
            ST_P_FREE:   sda_pull = !settled;
            ST_DONE:     done = 1'b1;
            default: begin
                sda_pull = 1'b0;
            end
        endcase
    end

    assert_req_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_rise && req_fall));

    assert_rise_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_rise && !rise_p) |=> req_rise);

    assert_fall_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_fall && !fall_p) |=> req_fall);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!sda_pull && !req_rise && !req_fall));

    assert_settle_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((SETTLE > 0) && $rose(req_rise || req_fall)) |-> $stable(sda_pull));

endmodule

// File: rtl/bus_cond_sequencer.sv
`timescale 1ns/1ps
module bus_cond_sequencer #(
    parameter int SETTLE = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_start,
    input  logic cmd_stop,
    input  logic sda_in,
    input  logic scl_rise_pulse,
    input  logic scl_fall_pulse,
    input  logic scl_fall_late_pulse,
    input  logic start_seen,
    input  logic stop_seen,
    output logic sda_pull,
    output logic req_rise,
    output logic req_fall,
    output logic done
);

    logic scl_hi;
    logic late_ok;
    logic settled;
    logic tmr_load;

    bcs_line_tracker u_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_p  (scl_rise_pulse),
        .fall_p  (scl_fall_pulse),
        .late_p  (scl_fall_late_pulse),
        .scl_hi  (scl_hi),
        .late_ok (late_ok)
    );

    bcs_settle_timer #(.SETTLE(SETTLE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .settled (settled)
    );

    bcs_seq_fsm #(.SETTLE(SETTLE)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_start  (cmd_start),
        .cmd_stop   (cmd_stop),
        .sda_in     (sda_in),
        .scl_hi     (scl_hi),
        .late_ok    (late_ok),
        .rise_p     (scl_rise_pulse),
        .fall_p     (scl_fall_pulse),
        .start_seen (start_seen),
        .stop_seen  (stop_seen),
        .settled    (settled),
        .tmr_load   (tmr_load),
        .sda_pull   (sda_pull),
        .req_rise   (req_rise),
        .req_fall   (req_fall),
        .done       (done)
    );

endmodule

// File: tb/bus_cond_sequencer_tb_top.sv
`timescale 1ns/1ps
module bus_cond_sequencer_tb_top;

    localparam int SETTLE = 5;
    localparam logic [2:0] EV_START = 3'd1;
    localparam logic [2:0] EV_STOP  = 3'd2;
    localparam logic [2:0] EV_FALL  = 3'd3;
    localparam logic [2:0] EV_RISE  = 3'd4;
    localparam logic [2:0] EV_DONE  = 3'd5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic cmd_stop = 1'b0;
    logic sda_in;
    logic rise_p = 1'b0, fall_p = 1'b0, late_p = 1'b0;
    logic start_p = 1'b0, stop_p = 1'b0;
    logic sda_pull, req_rise, req_fall, done;

    always #2.5 clk = ~clk;

    // bus model state
    logic scl_line = 1'b1;
    logic ext_low = 1'b0;
    int   ext_mode = 0;
    int   ext_cnt = 0;
    int   ext_req_mode = 0;
    int   ext_req_seq = 0;
    int   ext_seen_seq = 0;
    int   late_cnt = 0;
    int   resp_wait = 0;
    logic prev_sda = 1'b1;
    logic prev_pull = 1'b0;
    logic prev_req = 1'b0;
    int   cyc = 0;
    int   last_chg = -1;
    int   min_gap = 1000000;
    int   pull_cnt = 0;
    int   quiet_viol = 0;
    int   both_viol = 0;
    logic quiet_on = 1'b0;
    logic [2:0] ev_log [0:1023];
    int   ev_n = 0;

    int checks = 0;
    int fails = 0;

    assign sda_in = !(sda_pull || ext_low);

    bus_cond_sequencer #(.SETTLE(SETTLE)) dut_i (
        .clk                 (clk),
        .rst_n               (rst_n),
        .cmd_start           (cmd_start),
        .cmd_stop            (cmd_stop),
        .sda_in              (sda_in),
        .scl_rise_pulse      (rise_p),
        .scl_fall_pulse      (fall_p),
        .scl_fall_late_pulse (late_p),
        .start_seen          (start_p),
        .stop_seen           (stop_p),
        .sda_pull            (sda_pull),
        .req_rise            (req_rise),
        .req_fall            (req_fall),
        .done                (done)
    );

    task automatic add_ev(input logic [2:0] c);
        if (ev_n < 1024) begin
            ev_log[ev_n] = c;
            ev_n++;
        end
    endtask

    // clock controller, condition detectors and other bus device
    always @(negedge clk) begin
        logic sda_now;
        logic req_now;
        cyc++;
        rise_p  = 1'b0;
        fall_p  = 1'b0;
        late_p  = 1'b0;
        start_p = 1'b0;
        stop_p  = 1'b0;
        if (!rst_n) begin
            prev_sda = 1'b1;
        end else begin
            if (ext_req_seq != ext_seen_seq) begin
                ext_seen_seq = ext_req_seq;
                ext_low  = 1'b1;
                ext_mode = ext_req_mode;
                ext_cnt  = 12;
            end
            sda_now = !(sda_pull || ext_low);
            if (sda_now != prev_sda && scl_line) begin
                if (!sda_now) begin start_p = 1'b1; add_ev(EV_START); end
                else          begin stop_p  = 1'b1; add_ev(EV_STOP);  end
            end
            prev_sda = sda_now;
            if (req_fall && scl_line) begin
                if (resp_wait == 0) begin
                    scl_line = 1'b0;
                    fall_p = 1'b1;
                    add_ev(EV_FALL);
                    late_cnt = 3;
                    resp_wait = int'($urandom % 4);
                    if (ext_mode == 1) begin ext_low = 1'b0; ext_mode = 0; end
                end else resp_wait--;
            end else if (req_rise && !scl_line) begin
                if (resp_wait == 0) begin
                    scl_line = 1'b1;
                    rise_p = 1'b1;
                    add_ev(EV_RISE);
                    resp_wait = int'($urandom % 4);
                end else resp_wait--;
            end
            if (late_cnt > 0) begin
                late_cnt--;
                if (late_cnt == 0) late_p = 1'b1;
            end
            if (ext_mode == 2) begin
                if (ext_cnt == 0) begin ext_low = 1'b0; ext_mode = 0; end
                else ext_cnt--;
            end
            if (done) add_ev(EV_DONE);
            if (quiet_on && (sda_pull || req_rise || req_fall)) quiet_viol++;
            if (req_rise && req_fall) both_viol++;
            if (sda_pull) pull_cnt++;
            if (sda_pull != prev_pull) last_chg = cyc;
            prev_pull = sda_pull;
            req_now = req_rise || req_fall;
            if (req_now && !prev_req && last_chg >= 0) begin
                if (cyc - last_chg < min_gap) min_gap = cyc - last_chg;
            end
            prev_req = req_now;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] exp_seq(input bit st, input bit hi, input bit ex);
        logic [2:0] e [0:7];
        logic [23:0] v;
        for (int i = 0; i < 8; i++) e[i] = 3'd0;
        if (st) begin
            if (!hi) begin
                e[0] = EV_RISE; e[1] = EV_START; e[2] = EV_FALL; e[3] = EV_DONE;
            end else if (!ex) begin
                e[0] = EV_START; e[1] = EV_FALL; e[2] = EV_DONE;
            end else begin
                e[0] = EV_FALL; e[1] = EV_RISE; e[2] = EV_START; e[3] = EV_FALL; e[4] = EV_DONE;
            end
        end else begin
            if (!hi) begin
                e[0] = EV_RISE; e[1] = EV_STOP; e[2] = EV_DONE;
            end else if (!ex) begin
                e[0] = EV_FALL; e[1] = EV_RISE; e[2] = EV_STOP; e[3] = EV_DONE;
            end else begin
                e[0] = EV_STOP; e[1] = EV_DONE;
            end
        end
        v = '0;
        for (int i = 0; i < 8; i++) v[i*3 +: 3] = e[i];
        return v;
    endfunction

    task automatic run_case(input bit is_start, input bit both, input bit ext,
                            input bit hold, input bit busy, input string tag);
        bit st;
        int base, pbase, qbase, waited, n, after_done, done_idx;
        bit got;
        logic [23:0] expv, actv;
        st = is_start || both;
        if (ext) begin
            ext_req_mode = st ? 1 : 2;
            ext_req_seq++;
            repeat (3) @(negedge clk);
        end
        expv  = exp_seq(st, scl_line, ext);
        base  = ev_n;
        pbase = pull_cnt;
        qbase = quiet_viol;
        cmd_start = is_start || both;
        cmd_stop  = !is_start || both;
        waited = 0;
        got = 1'b0;
        while (!got && waited < 3000) begin
            @(negedge clk);
            waited++;
            if (busy && waited == 3) begin cmd_start = 1'b0; cmd_stop = 1'b0; end
            if (busy && waited == 4) begin
                if (st) cmd_stop = 1'b1; else cmd_start = 1'b1;
            end
            if (busy && waited == 7) begin cmd_start = 1'b0; cmd_stop = 1'b0; end
            if (done) got = 1'b1;
        end
        check(got, {tag, " done reached"}, int'(got), 1);
        @(negedge clk);
        check(done == 1'b0, "R10 done lasts one cycle", int'(done), 0);
        quiet_on = 1'b1;
        if (hold) repeat (30) @(negedge clk);
        cmd_start = 1'b0;
        cmd_stop  = 1'b0;
        repeat (20) @(negedge clk);
        quiet_on = 1'b0;
        n = ev_n - base;
        actv = '0;
        done_idx = -1;
        for (int i = 0; i < n && i < 8; i++) begin
            actv[i*3 +: 3] = ev_log[base + i];
            if (ev_log[base + i] == EV_DONE && done_idx < 0) done_idx = i;
        end
        if (n > 8) actv = 24'hFFFFFF;
        check(actv == expv, {tag, " bus event order"}, int'(actv), int'(expv));
        check(quiet_viol == qbase, "R10 quiet after done", quiet_viol - qbase, 0);
        if (hold) begin
            after_done = (done_idx < 0) ? n : n - done_idx - 1;
            check(after_done == 0, "R12 held command starts nothing", after_done, 0);
        end
        if (ext && !st)
            check(pull_cnt == pbase, "R8 no pull while other device holds data", pull_cnt - pbase, 0);
        if (st && !ext && expv[2:0] == EV_START)
            check(pull_cnt > pbase, "R1 own pull makes START", pull_cnt - pbase, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        check({sda_pull, req_rise, req_fall, done} == 4'b0, "R11 outputs in reset",
              int'({sda_pull, req_rise, req_fall, done}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({sda_pull, req_rise, req_fall, done} == 4'b0, "R11 outputs after reset",
              int'({sda_pull, req_rise, req_fall, done}), 0);
        repeat (3) @(negedge clk);

        run_case(1, 0, 0, 1, 0, "R3");          // idle START, held afterwards
        run_case(1, 0, 0, 0, 0, "R5");          // repeated START
        run_case(0, 0, 0, 1, 0, "R6");          // STOP from clock low
        check(scl_line == 1'b1, "R6 clock left high", int'(scl_line), 1);
        run_case(0, 0, 0, 0, 0, "R7");          // STOP from clock high
        run_case(0, 0, 1, 0, 0, "R8");          // STOP, data held low
        run_case(1, 0, 1, 0, 0, "R4");          // START, data held low
        run_case(0, 1, 0, 0, 0, "R13 both");    // both: START wins
        run_case(0, 0, 0, 0, 1, "R13 busy");    // STOP with stray START
        run_case(1, 0, 0, 0, 1, "R13 busy");    // START with stray STOP

        for (int k = 0; k < 36; k++) begin
            bit s, b, e, h, y;
            s = ($urandom % 2) == 0;
            b = s && (($urandom % 4) == 0);
            e = scl_line && (($urandom % 3) == 0);
            y = ($urandom % 4) == 0;
            h = !y && (($urandom % 2) == 0);
            run_case(s, b, e, h, y, s ? "R3/R4/R5 random" : "R6/R7/R8 random");
        end

        check(both_viol == 0, "R2 requests never overlap", both_viol, 0);
        check(min_gap == SETTLE, "R9 settle gap", min_gap, SETTLE);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule